// File: doc/BRIEF.md
# USB Clock-Request Activity Timer

This block tells the clock and power logic of a chip when the USB device core needs its 48 MHz clock. A single level output, the clock-request flag, goes high as soon as the core reports activity on the data pins, a finished packet or a suspend-state change. It stays high while events keep arriving. It falls after a hold-off interval that depends on the kind of event that came last. After a completed packet the hold-off is long (5 ms by default). After a suspend change it is short (2 ms by default). Software sees the flag as a read-only status bit.

The hold-off is measured in milliseconds. A prescaler counts system clock cycles to make each millisecond, and the cycle count is a parameter, so a test can use a very short millisecond. A single countdown holds the remaining milliseconds, and each event reloads it. When the flag goes from 0 to 1 and the wakeup enable is high, the block gives a one-cycle wakeup request for the power controller.

Top module: `usb_clkreq_timer`

## Requirements
- R1: After reset, need_clk_o and wake_req_o are both 0.
- R2: Any event pulse (bus_act_i, pkt_done_i or susp_chg_i) sampled at a clock edge makes need_clk_o 1 after that edge.
- R3: A pkt_done_i pulse with no susp_chg_i in the same cycle, sampled at edge E, arms the long hold. Without later events, need_clk_o stays 1 up to edge E+PKT_MS*TICK_DIV and is 0 after it.
- R4: A susp_chg_i pulse sampled at edge E arms the short hold. Without later events, need_clk_o is 0 after edge E+SUSP_MS*TICK_DIV and 1 before it.
- R5: A new pkt_done_i while the long hold runs restarts it at full length from the new event.
- R6: If both kinds of event occur, the most recent one decides the release time. A pkt_done_i after a susp_chg_i gives the long hold from the pkt_done_i. A susp_chg_i after a pkt_done_i gives the short hold from the susp_chg_i.
- R7: If susp_chg_i and pkt_done_i occur in the same cycle, the short hold is armed.
- R8: A bus_act_i pulse reloads the hold that is running at its full length. If no hold is running, it arms the long hold.
- R9: wake_req_o is a one-cycle pulse, high in the first cycle in which need_clk_o is 1, when wake_en_i was 1 at the setting edge. Events that arrive while the flag is already 1 give no pulse.
- R10: With wake_en_i at 0, wake_req_o stays 0. The flag itself behaves the same as with wake_en_i at 1.
- R11: An event sampled at the same edge at which a hold would expire keeps need_clk_o at 1 and arms a new hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| bus_act_i | input | 1 | Pulse: data-pin activity or a change of pin state |
| pkt_done_i | input | 1 | Pulse: a packet was received or sent |
| susp_chg_i | input | 1 | Pulse: the suspend state changed |
| wake_en_i | input | 1 | Allows the rising edge of the flag to request a wakeup |
| need_clk_o | output | 1 | Clock-request flag (read-only status) |
| wake_req_o | output | 1 | One-cycle wakeup request on the rising edge of the flag |

## Verification
The assertions check these rules on every cycle:
- Every event leaves the flag set.
- The flag falls only on an expiry of the countdown.
- The hold kind tracks the last event and whether a hold is running.
- A wakeup pulse appears only on a rising flag with the enable high.
- The millisecond prescaler and the countdown stay in range.

Only the bench scenarios can show the exact release cycles. These cover the long and short holds, restarts, the last-event-wins ordering, simultaneous events and an event on the expiry edge. The bench also shows that no wakeup pulse appears while the enable is low or while the flag is already set.

// File: rtl/usbclk_pkg.sv
package usbclk_pkg;

   typedef enum logic [1:0] {
      HOLD_NONE  = 2'd0,
      HOLD_LONG  = 2'd1,
      HOLD_SHORT = 2'd2
   } hold_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/usbclk_ms_tick.sv
module usbclk_ms_tick #(
   parameter int unsigned DIV = 48000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic tick
);

   if (DIV < 1) begin : g_bad_div
      $error("usbclk_ms_tick: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_direct
      assign tick = run & ~restart;
   end else begin : g_count
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pre_q <= '0;
         end else if (restart || !run) begin
            pre_q <= '0;
         end else if (pre_q == LAST) begin
            pre_q <= '0;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end

      assign tick = run && !restart && (pre_q == LAST);

      // R3: the prescaler never runs past its last count
      p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
         pre_q <= LAST);

      // R3: a restart always starts a fresh millisecond
      p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
         restart |=> (pre_q == '0));
   end

endmodule

// File: rtl/usbclk_holdoff.sv
module usbclk_holdoff #(
   parameter int unsigned MAX_MS = 5,
   parameter int unsigned LW     = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [LW-1:0] load_len,
   input  logic          tick,
   output logic          armed,
   output logic          expire
);

   if (MAX_MS < 1) begin : g_bad_max
      $error("usbclk_holdoff: MAX_MS must be at least 1");
   end
   if ((2 ** LW) <= MAX_MS) begin : g_bad_lw
      $error("usbclk_holdoff: LW too narrow for MAX_MS");
   end

   logic [LW-1:0] rem_q;
   logic          armed_q;

   assign expire = armed_q && tick && (rem_q == LW'(1)) && !load;
   assign armed  = armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q   <= '0;
         armed_q <= 1'b0;
      end else if (load) begin
         rem_q   <= load_len;
         armed_q <= 1'b1;
      end else if (expire) begin
         rem_q   <= '0;
         armed_q <= 1'b0;
      end else if (armed_q && tick) begin
         rem_q   <= rem_q - 1'b1;
      end
   end

   // R3: a running hold always has milliseconds left
   p_rem_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (rem_q != '0 && rem_q <= LW'(MAX_MS)));

   // R4: a load never asks for a zero-length hold
   p_load_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_len != '0));

   // R11: a load wins over an expiry in the same cycle
   p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> armed_q);

endmodule

// File: rtl/usbclk_event_arb.sv
module usbclk_event_arb
   import usbclk_pkg::*;
#(
   parameter int unsigned PKT_MS  = 5,
   parameter int unsigned SUSP_MS = 2,
   parameter int unsigned LW      = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act,
   input  logic          pkt,
   input  logic          susp,
   input  logic          armed,
   input  logic          expire,
   output logic          load,
   output logic [LW-1:0] load_len
);

   hold_e mode_q;
   hold_e mode_d;
   hold_e act_mode;

   assign act_mode = (armed && mode_q == HOLD_SHORT) ? HOLD_SHORT : HOLD_LONG;
   assign load     = act | pkt | susp;

   always_comb begin
      if (susp) begin
         mode_d = HOLD_SHORT;
      end else if (pkt) begin
         mode_d = HOLD_LONG;
      end else begin
         mode_d = act_mode;
      end
   end

   assign load_len = (mode_d == HOLD_SHORT) ? LW'(SUSP_MS) : LW'(PKT_MS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= HOLD_NONE;
      end else if (load) begin
         mode_q <= mode_d;
      end else if (expire) begin
         mode_q <= HOLD_NONE;
      end
   end

   // R6: the recorded hold kind agrees with whether a countdown runs
   p_mode_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != HOLD_NONE) == armed);

   // R7: a suspend change always selects the short hold
   p_susp_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
      susp |=> (mode_q == HOLD_SHORT));

   // R5: a packet without a suspend change selects the long hold
   p_pkt_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt && !susp) |=> (mode_q == HOLD_LONG));

endmodule

// File: rtl/usb_clkreq_timer.sv
module usb_clkreq_timer
   import usbclk_pkg::*;
#(
   parameter int unsigned TICK_DIV = 48000,
   parameter int unsigned PKT_MS   = 5,
   parameter int unsigned SUSP_MS  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_act_i,
   input  logic pkt_done_i,
   input  logic susp_chg_i,
   input  logic wake_en_i,
   output logic need_clk_o,
   output logic wake_req_o
);

   localparam int unsigned MAX_MS = max_u(PKT_MS, SUSP_MS);
   localparam int unsigned LW     = $clog2(MAX_MS + 1);

   if (PKT_MS < 1 || SUSP_MS < 1) begin : g_bad_hold
      $error("usb_clkreq_timer: hold lengths must be at least 1 ms");
   end

   logic          load;
   logic [LW-1:0] load_len;
   logic          tick;
   logic          armed;
   logic          expire;
   logic          wake_q;
   logic          any_ev;

   assign any_ev = bus_act_i | pkt_done_i | susp_chg_i;

   usbclk_event_arb #(
      .PKT_MS  (PKT_MS),
      .SUSP_MS (SUSP_MS),
      .LW      (LW)
   ) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (bus_act_i),
      .pkt      (pkt_done_i),
      .susp     (susp_chg_i),
      .armed    (armed),
      .expire   (expire),
      .load     (load),
      .load_len (load_len)
   );

   usbclk_ms_tick #(
      .DIV (TICK_DIV)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (load),
      .run     (armed),
      .tick    (tick)
   );

   usbclk_holdoff #(
      .MAX_MS (MAX_MS),
      .LW     (LW)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_len (load_len),
      .tick     (tick),
      .armed    (armed),
      .expire   (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wake_q <= 1'b0;
      end else begin
         wake_q <= wake_en_i && any_ev && !armed;
      end
   end

   assign need_clk_o = armed;
   assign wake_req_o = wake_q;

   // R2: every event leaves the flag set
   p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      any_ev |=> need_clk_o);

   // R3: the flag only falls on a countdown expiry
   p_fall_on_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(need_clk_o) |-> $past(expire));

   // R9: a wakeup pulse only marks the first cycle of a set flag
   p_wake_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req_o |-> (need_clk_o && !$past(need_clk_o)));

   // R10: no wakeup pulse while the enable is low
   p_wake_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wake_en_i |=> !wake_req_o);

endmodule

// File: tb/usb_clkreq_timer_bench.sv
module usb_clkreq_timer_bench;

   localparam int unsigned DIV  = 4;
   localparam int unsigned LMS  = 5;
   localparam int unsigned SMS  = 2;
   localparam int          LONG  = LMS * DIV;
   localparam int          SHORT = SMS * DIV;

   localparam int K_RISE = 0;
   localparam int K_FALL = 1;
   localparam int K_WAKE = 2;

   typedef struct {
      int    kind;
      int    cyc;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_act = 1'b0;
   logic pkt_done = 1'b0;
   logic susp_chg = 1'b0;
   logic wake_en = 1'b0;
   logic need_clk;
   logic wake_req;

   int   cyc = 0;
   int   tests = 0;
   int   fails = 0;
   bit   done = 1'b0;
   exp_t q[$];
   logic prev_n = 1'b0;
   logic prev_w = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   usb_clkreq_timer #(
      .TICK_DIV (DIV),
      .PKT_MS   (LMS),
      .SUSP_MS  (SMS)
   ) u_usb_clkreq_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_act_i  (bus_act),
      .pkt_done_i (pkt_done),
      .susp_chg_i (susp_chg),
      .wake_en_i  (wake_en),
      .need_clk_o (need_clk),
      .wake_req_o (wake_req)
   );

   task automatic push(input int kind, input int c, input string tag);
      exp_t it;
      it.kind = kind;
      it.cyc  = c;
      it.tag  = tag;
      q.push_back(it);
   endtask

   task automatic got(input int kind);
      exp_t it;
      tests++;
      if (q.size() == 0) begin
         fails++;
         $display("FAIL unexpected event: actual kind %0d at edge %0d, expected none", kind, cyc);
      end else begin
         it = q.pop_front();
         if (it.kind != kind || it.cyc != cyc) begin
            fails++;
            $display("FAIL %s: actual kind %0d at edge %0d, expected kind %0d at edge %0d",
                     it.tag, kind, cyc, it.kind, it.cyc);
         end
      end
   endtask

   task automatic check_bit(input string tag, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b, expected %b", tag, act, exp);
      end
   endtask

   // drive a pulse so that it is sampled at edge t
   task automatic fire(input int t, input bit a, input bit p, input bit s);
      while (cyc < t - 1) @(negedge clk);
      bus_act  = a;
      pkt_done = p;
      susp_chg = s;
      @(negedge clk);
      bus_act  = 1'b0;
      pkt_done = 1'b0;
      susp_chg = 1'b0;
   endtask

   task automatic settle(input int until_edge, input string tag);
      while (cyc < until_edge + 4) @(negedge clk);
      tests++;
      if (q.size() != 0) begin
         fails++;
         $display("FAIL %s: actual %0d events missing, expected 0", tag, q.size());
         q.delete();
      end
   endtask

   // monitor: compares each output transition with the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (need_clk !== prev_n) begin
            got(need_clk ? K_RISE : K_FALL);
            prev_n = need_clk;
         end
         if (wake_req && !prev_w) got(K_WAKE);
         if (wake_req && prev_w) begin
            tests++;
            fails++;
            $display("FAIL R9: actual wake pulse longer than 1 cycle at edge %0d, expected 1 cycle", cyc);
         end
         prev_w = wake_req;
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual run still busy, expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : driver
      int b;
      repeat (3) @(negedge clk);
      check_bit("R1 need_clk in reset", need_clk, 1'b0);
      check_bit("R1 wake_req in reset", wake_req, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_bit("R1 need_clk after reset", need_clk, 1'b0);
      check_bit("R1 wake_req after reset", wake_req, 1'b0);

      // R2 R8 R9: activity from idle arms the long hold and wakes
      wake_en = 1'b1;
      b = cyc + 2;
      push(K_RISE, b, "R2");
      push(K_WAKE, b, "R9");
      push(K_FALL, b + LONG, "R8");
      fire(b, 1, 0, 0);
      settle(b + LONG, "R8 idle activity");

      // R3 R10: packet with wakeup disabled
      wake_en = 1'b0;
      b = cyc + 2;
      push(K_RISE, b, "R3");
      push(K_FALL, b + LONG, "R3");
      fire(b, 0, 1, 0);
      settle(b + LONG, "R10 no wake");

      // R4: suspend change, short hold
      wake_en = 1'b1;
      b = cyc + 2;
      push(K_RISE, b, "R4");
      push(K_WAKE, b, "R9");
      push(K_FALL, b + SHORT, "R4");
      fire(b, 0, 0, 1);
      settle(b + SHORT, "R4 short");

      // R5 R9: packet restarts long hold, no second wake
      b = cyc + 2;
      push(K_RISE, b, "R5");
      push(K_WAKE, b, "R9");
      push(K_FALL, b + 10 + LONG, "R5");
      fire(b, 0, 1, 0);
      fire(b + 10, 0, 1, 0);
      settle(b + 10 + LONG, "R5 restart");

      // R6: suspend after packet gives short from suspend
      wake_en = 1'b0;
      b = cyc + 2;
      push(K_RISE, b, "R6");
      push(K_FALL, b + 3 + SHORT, "R6 susp last");
      fire(b, 0, 1, 0);
      fire(b + 3, 0, 0, 1);
      settle(b + 3 + SHORT, "R6 susp last");

      // R6: packet after suspend gives long from packet
      b = cyc + 2;
      push(K_RISE, b, "R6");
      push(K_FALL, b + 5 + LONG, "R6 pkt last");
      fire(b, 0, 0, 1);
      fire(b + 5, 0, 1, 0);
      settle(b + 5 + LONG, "R6 pkt last");

      // R7: simultaneous events pick short
      b = cyc + 2;
      push(K_RISE, b, "R7");
      push(K_FALL, b + SHORT, "R7");
      fire(b, 0, 1, 1);
      settle(b + SHORT, "R7 same cycle");

      // R8: activity reloads a running short hold
      b = cyc + 2;
      push(K_RISE, b, "R8");
      push(K_FALL, b + 5 + SHORT, "R8 reload short");
      fire(b, 0, 0, 1);
      fire(b + 5, 1, 0, 0);
      settle(b + 5 + SHORT, "R8 reload short");

      // R8: activity reloads a running long hold
      b = cyc + 2;
      push(K_RISE, b, "R8");
      push(K_FALL, b + 12 + LONG, "R8 reload long");
      fire(b, 0, 1, 0);
      fire(b + 12, 1, 0, 0);
      settle(b + 12 + LONG, "R8 reload long");

      // R11: packet on the expiry edge of a short hold
      b = cyc + 2;
      push(K_RISE, b, "R11");
      push(K_FALL, b + SHORT + LONG, "R11");
      fire(b, 0, 0, 1);
      fire(b + SHORT, 0, 1, 0);
      check_bit("R11 flag held at expiry edge", need_clk, 1'b1);
      settle(b + SHORT + LONG, "R11 expiry edge");

      check_bit("R1 idle at end", need_clk, 1'b0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule